// File: doc/BRIEF.md
# Method Write Emitter

This block sits behind a macro-execution core and turns its output stream into downstream method writes: pairs of a 16-bit byte address and a 32-bit data word. The core opens a method by presenting a packed 16-bit word. The word holds a register offset and an address stride. The core then emits data words, and those words collect in a small buffer. On a flush, every buffered word goes out over a valid/ready port in the order it was emitted. Each word gets its own address, and the stride advances the address from one word to the next. When the flush completes, no method is pending.

The core must flush before any state read and at the end of its program. Opening a new method implicitly flushes the previous one. While the block drains, it raises `busy`. Set, emit and flush requests presented while `busy` is high are ignored, so the core must hold them until `busy` falls. A request counts only in a cycle where `busy` is low at the clock edge. Misuse of the buffer raises a one-cycle error pulse, and the offending word is dropped.

Top module: `meth_emit`

## Requirements
- R1: During and right after reset, `outValid`, `busy` and `errPulse` are 0.
- R2: The first word of a method goes to byte address `{setWord[11:0], 2'b00}`.
- R3: Each following word of the same method goes to the previous address plus `setWord[15:12] * 4`, modulo 2^16.
- R4: Buffered words leave in emit order, each exactly once, carrying the emitted data.
- R5: At most 8 words are buffered per method. A ninth emit is dropped and flagged as an error.
- R6: An emit while no method is pending is dropped and flagged as an error.
- R7: A set request while a method with words is pending first drains those words under the old address. The new method then starts with an empty buffer.
- R8: A flush with no method pending, or with a method that holds no words, sends nothing. After any flush, no method is pending.
- R9: `busy` and `outValid` are high from the cycle after a flush begins until the last word is taken. Set, emit and flush requests in those cycles have no effect.
- R10: While `outValid` is high and `outReady` is low, `outAddr` and `outData` hold their values.
- R11: Requests in the same accepted cycle act in the order set, then emit, then flush. An emit alongside a set becomes the first word of the new method.
- R12: `errPulse` is high for exactly the cycle after an accepted erroneous emit, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Open a new method this cycle |
| setWord | input | 16 | Packed method word: [11:0] register offset, [15:12] stride |
| emitValid | input | 1 | Append a data word this cycle |
| emitData | input | 32 | Data word to append |
| flushReq | input | 1 | Send all buffered words of the pending method |
| busy | output | 1 | Draining; requests are ignored |
| errPulse | output | 1 | One-cycle pulse after a dropped emit |
| outValid | output | 1 | Method write available |
| outReady | input | 1 | Downstream accepts the method write |
| outAddr | output | 16 | Byte address of the method write |
| outData | output | 32 | Data of the method write |

## Verification
The set and emit functions can coincide in one accepted cycle, and a flush can join them. When an older method still holds words, the block must then drain two methods back to back without going idle in between. The bench drives set, emit and flush together, both after a method has been filled and while nothing is pending. It also mixes them at random against a random `outReady`. A behavioural queue model applies the three requests in set, emit, flush order and predicts each address, each data word, the `busy` level and the error pulse. Those predictions are compared on every clock.

// File: rtl/meth_emit_pkg.sv
package meth_emit_pkg;

  typedef enum logic {ST_IDLE, ST_DRAIN} emitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic bufWrite;       // write one buffer entry
    logic bufFromHold;    // entry comes from the held word, not emitData
    logic methodLoad;     // take setWord as the active method
    logic methodPromote;  // take the shadow word as the active method
    logic nextCapture;    // park setWord and emitData for later
  } emitStrobes_t;

endpackage

// File: rtl/meth_emit_dp.sv
module meth_emit_dp
  import meth_emit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 12,
  parameter int STEP_W = 4,
  localparam int SET_W = OFFS_W + STEP_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  emitStrobes_t      strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [SET_W-1:0]  setWord,
  input  logic [DATA_W-1:0] emitData,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] buffer [DEPTH];
  logic [SET_W-1:0]  methodWord;
  logic [SET_W-1:0]  shadowWord;
  logic [DATA_W-1:0] holdData;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] stride;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      methodWord <= '0;
      shadowWord <= '0;
      holdData   <= '0;
    end else begin
      if (strobe.methodLoad)
        methodWord <= setWord;
      else if (strobe.methodPromote)
        methodWord <= shadowWord;
      if (strobe.nextCapture) begin
        shadowWord <= setWord;
        holdData   <= emitData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.bufWrite)
      buffer[wrIdx] <= strobe.bufFromHold ? holdData : emitData;
  end

  assign baseAddr = ADDR_W'({methodWord[OFFS_W-1:0], 2'b00});
  assign stride   = ADDR_W'({methodWord[SET_W-1:OFFS_W], 2'b00});
  assign outAddr  = baseAddr + ADDR_W'(rdIdx) * stride;
  assign outData  = buffer[rdIdx];

  // consecutive words of one method are one stride apart
  assert_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdx != '0 && rdIdx == $past(rdIdx) + 1'b1 && $stable(methodWord))
      |-> outAddr == $past(outAddr) + stride);

endmodule

// File: rtl/meth_emit_ctrl.sv
module meth_emit_ctrl
  import meth_emit_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setValid,
  input  logic             emitValid,
  input  logic             flushReq,
  input  logic             outReady,
  output emitStrobes_t     strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             outValid,
  output logic             busy,
  output logic             errPulse
);

  emitState_t       state, nState;
  logic             pending, nPending;
  logic [CNT_W-1:0] count, nCount;
  logic [IDX_W-1:0] nRdIdx;
  logic             nextValid, nNextValid;
  logic             holdValid, nHoldValid;
  logic             flushLater, nFlushLater;
  logic             errNext;
  logic             pTmp;
  logic [CNT_W-1:0] cTmp;
  logic             lastWord;

  assign lastWord = (CNT_W'(rdIdx) == count - CNT_W'(1));

  always_comb begin
    nState      = state;
    nPending    = pending;
    nCount      = count;
    nRdIdx      = rdIdx;
    nNextValid  = nextValid;
    nHoldValid  = holdValid;
    nFlushLater = flushLater;
    errNext     = 1'b0;
    strobe      = '0;
    wrIdx       = count[IDX_W-1:0];
    pTmp        = pending;
    cTmp        = count;
    case (state)
      ST_IDLE: begin
        if (setValid && pending && count != '0) begin
          // old words must leave first; park the new request
          strobe.nextCapture = 1'b1;
          nNextValid  = 1'b1;
          nHoldValid  = emitValid;
          nFlushLater = flushReq;
          nState      = ST_DRAIN;
          nRdIdx      = '0;
        end else begin
          if (setValid) begin
            strobe.methodLoad = 1'b1;
            pTmp = 1'b1;
            cTmp = '0;
          end
          if (emitValid) begin
            if (!pTmp || cTmp == CNT_W'(DEPTH)) begin
              errNext = 1'b1;
            end else begin
              strobe.bufWrite = 1'b1;
              wrIdx = cTmp[IDX_W-1:0];
              cTmp  = cTmp + 1'b1;
            end
          end
          if (flushReq && pTmp) begin
            if (cTmp != '0) begin
              nState      = ST_DRAIN;
              nRdIdx      = '0;
              nNextValid  = 1'b0;
              nHoldValid  = 1'b0;
              nFlushLater = 1'b0;
            end else begin
              pTmp = 1'b0;
            end
          end
          nPending = pTmp;
          nCount   = cTmp;
        end
      end
      ST_DRAIN: begin
        if (outReady) begin
          if (lastWord) begin
            nRdIdx = '0;
            if (nextValid) begin
              strobe.methodPromote = 1'b1;
              nNextValid = 1'b0;
              nPending   = 1'b1;
              if (holdValid) begin
                strobe.bufWrite    = 1'b1;
                strobe.bufFromHold = 1'b1;
                wrIdx      = '0;
                nCount     = CNT_W'(1);
                nHoldValid = 1'b0;
                if (flushLater) nFlushLater = 1'b0;  // stay draining
                else            nState = ST_IDLE;
              end else begin
                nCount = '0;
                nState = ST_IDLE;
                if (flushLater) begin
                  nPending    = 1'b0;
                  nFlushLater = 1'b0;
                end
              end
            end else begin
              nPending = 1'b0;
              nCount   = '0;
              nState   = ST_IDLE;
            end
          end else begin
            nRdIdx = rdIdx + 1'b1;
          end
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pending    <= 1'b0;
      count      <= '0;
      rdIdx      <= '0;
      nextValid  <= 1'b0;
      holdValid  <= 1'b0;
      flushLater <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      state      <= nState;
      pending    <= nPending;
      count      <= nCount;
      rdIdx      <= nRdIdx;
      nextValid  <= nNextValid;
      holdValid  <= nHoldValid;
      flushLater <= nFlushLater;
      errPulse   <= errNext;
    end
  end

  assign outValid = (state == ST_DRAIN);
  assign busy     = (state != ST_IDLE);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_err_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> $past(emitValid) && !$past(busy));

  assert_drain_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> count != '0 && pending);

endmodule

// File: rtl/meth_emit.sv
module meth_emit
  import meth_emit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 12,
  parameter int STEP_W = 4,
  localparam int SET_W = OFFS_W + STEP_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setValid,
  input  logic [SET_W-1:0]  setWord,
  input  logic              emitValid,
  input  logic [DATA_W-1:0] emitData,
  input  logic              flushReq,
  output logic              busy,
  output logic              errPulse,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);

  emitStrobes_t     strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  meth_emit_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .setValid  (setValid),
    .emitValid (emitValid),
    .flushReq  (flushReq),
    .outReady  (outReady),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .outValid  (outValid),
    .busy      (busy),
    .errPulse  (errPulse)
  );

  meth_emit_dp #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .STEP_W (STEP_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx),
    .setWord  (setWord),
    .emitData (emitData),
    .outAddr  (outAddr),
    .outData  (outData)
  );

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid && $stable(outAddr) && $stable(outData));

endmodule

// File: tb/sim_meth_emit.sv
`timescale 1ns/1ps
module sim_meth_emit;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setValid = 1'b0;
  logic [15:0] setWord = '0;
  logic        emitValid = 1'b0;
  logic [31:0] emitData = '0;
  logic        flushReq = 1'b0;
  logic        outReady = 1'b0;
  logic        busy, errPulse, outValid;
  logic [15:0] outAddr;
  logic [31:0] outData;

  always #2 clk = ~clk;  // 250 MHz

  meth_emit u0 (
    .clk(clk), .rst_n(rst_n), .setValid(setValid), .setWord(setWord),
    .emitValid(emitValid), .emitData(emitData), .flushReq(flushReq),
    .busy(busy), .errPulse(errPulse), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outData(outData)
  );

  typedef struct {
    logic [15:0] a;
    logic [31:0] d;
    bit          first;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] modBuf[$];
  bit          modPending = 0;
  logic [15:0] modWord = '0;
  bit          expErr = 0;
  bit          stallPrev = 0;
  logic [15:0] prevAddr;
  logic [31:0] prevData;
  string       dataTag = "R4";
  string       errTag = "R12";
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void modFlush();
    if (!modPending) return;
    for (int i = 0; i < modBuf.size(); i++) begin
      exp_t e;
      int   a;
      a = ({modWord[11:0], 2'b00}) + i * modWord[15:12] * 4;
      e.a = a[15:0];
      e.d = modBuf[i];
      e.first = (i == 0);
      expQ.push_back(e);
    end
    modBuf.delete();
    modPending = 0;
  endfunction

  task automatic step(bit s, logic [15:0] sw, bit e, logic [31:0] ed, bit f, bit rdy);
    bit accepted;
    @(negedge clk);
    chk(busy == (expQ.size() != 0), "R9", "busy", busy, expQ.size() != 0);
    chk(outValid == (expQ.size() != 0), "R9", "outValid", outValid, expQ.size() != 0);
    chk(errPulse == expErr, errTag, "errPulse", errPulse, expErr);
    if (stallPrev)
      chk(outAddr == prevAddr && outData == prevData, "R10", "held word",
          {outAddr, outData[15:0]}, {prevAddr, prevData[15:0]});
    if (outValid && expQ.size() != 0) begin
      chk(outAddr == expQ[0].a, expQ[0].first ? "R2" : "R3", "outAddr", outAddr, expQ[0].a);
      chk(outData == expQ[0].d, dataTag, "outData", outData, expQ[0].d);
    end
    accepted  = !busy;
    stallPrev = outValid && !rdy;
    prevAddr  = outAddr;
    prevData  = outData;
    if (outValid && rdy && expQ.size() != 0) void'(expQ.pop_front());
    setValid  = s;  setWord  = sw;
    emitValid = e;  emitData = ed;
    flushReq  = f;  outReady = rdy;
    expErr = 0;
    if (accepted) begin
      if (s) begin modFlush(); modPending = 1; modWord = sw; modBuf.delete(); end
      if (e) begin
        if (!modPending || modBuf.size() == DEPTH) expErr = 1;
        else modBuf.push_back(ed);
      end
      if (f) modFlush();
    end
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, rdy);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && (busy || expQ.size() != 0); i++) step(0, 0, 0, 0, 0, 1);
    idle(1, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!outValid, "R1", "outValid in reset", outValid, 0);
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!errPulse, "R1", "errPulse in reset", errPulse, 0);
    rst_n = 1'b1;
    idle(1, 1);
    chk(!outValid && !busy && !errPulse, "R1", "after reset", {outValid, busy, errPulse}, 0);

    // R6: emit with nothing pending
    errTag = "R6";
    step(0, 0, 1, 32'hDEAD0001, 0, 1);
    idle(1, 1);
    errTag = "R12";

    // R2, R3, R4: basic method, stride 3 words
    step(1, 16'h3010, 0, 0, 0, 1);
    step(0, 0, 1, 32'h11111111, 0, 1);
    step(0, 0, 1, 32'h22222222, 0, 1);
    step(0, 0, 1, 32'h33333333, 1, 1);
    drain();

    // R10: back-pressure during drain
    step(1, 16'hA123, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 32'hB000 + i, 0, 1);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, (i % 3) == 2);
    drain();

    // R5: ninth emit dropped
    errTag = "R5"; dataTag = "R5";
    step(1, 16'hFFFF, 0, 0, 0, 1);
    for (int i = 0; i < 9; i++) step(0, 0, 1, 32'hC0DE0000 + i, 0, 1);
    step(0, 0, 1, 32'hC0DE0099, 1, 1);  // emit on full plus flush
    drain();

    // R7: new method while old holds words
    errTag = "R12"; dataTag = "R7";
    step(1, 16'h1100, 0, 0, 0, 1);
    step(0, 0, 1, 32'h70000001, 0, 1);
    step(0, 0, 1, 32'h70000002, 0, 1);
    step(1, 16'h2200, 0, 0, 0, 1);
    step(0, 0, 1, 32'h70000003, 0, 1);  // R9: ignored while busy
    drain();
    step(0, 0, 1, 32'h70000004, 1, 1);
    drain();

    // R8: empty flushes; nothing pending afterwards
    errTag = "R8"; dataTag = "R8";
    step(0, 0, 0, 0, 1, 1);
    step(1, 16'h0040, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 1, 32'h80000001, 0, 1);
    idle(2, 1);

    // R11: set, emit and flush in one cycle
    errTag = "R12"; dataTag = "R11";
    step(1, 16'h5004, 1, 32'h90000001, 1, 1);
    drain();
    step(1, 16'h2008, 0, 0, 0, 1);
    step(0, 0, 1, 32'h90000002, 0, 1);
    step(0, 0, 1, 32'h90000003, 0, 1);
    step(1, 16'h7FF0, 1, 32'h90000004, 1, 0);
    for (int i = 0; i < 6; i++) step(1, 16'h0001, 1, 32'hEEEE, 1, i[0]);  // R9
    drain();
    step(1, 16'h4100, 0, 0, 0, 1);
    step(0, 0, 1, 32'h90000005, 0, 1);
    step(1, 16'h4200, 1, 32'h90000006, 0, 1);
    drain();
    step(0, 0, 0, 0, 1, 1);
    drain();

    // random mix of all requests
    dataTag = "R4"; errTag = "R12";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 12, 16'($urandom), r >= 8 && r < 70, $urandom, r >= 60 && r < 78,
           $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, 0, 1, 1);
    drain();
    chk(expQ.size() == 0, "R4", "words left unsent", expQ.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule